// File: doc/BRIEF.md
# Triggered Multichannel Acquisition Sequencer

This block is a bus peripheral with two sides. The slave side holds four 32-bit software registers in a 16-byte window at a configurable base address. One register combines a run control bit with a live view of eight debug switch inputs. Two registers hold analog output values, which leave the block as output ports. The fourth is a free scratch word.

The master side owns a simple request/acknowledge transfer port. When software sets the run bit, the sequencer first loads the bus addresses of an external analog input card. It then loops over sweeps. Each sweep is one write to the card's board control register, which makes the card latch every active channel at once, followed by one read per active channel from the card's input buffer. Each fetched word can be byte-reversed to turn little-endian bus data into big-endian order. It is then presented on a sample port with its channel index and a one-cycle valid strobe.

The run bit is checked only at a sweep boundary. A sweep in progress always completes, and the channel count is captured when the trigger completes. The card must already be configured by software before the run bit is set.

Top module: `acq_sequencer`

## Requirements
- R1: After reset, m_req, samp_valid and s_ack are 0, both analog outputs are 0, the registers at offsets 0x4, 0x8 and 0xC read 0, and the run bit reads 0.
- R2: A slave access whose word-aligned address falls in the window BASE_ADDR..BASE_ADDR+0xF is acknowledged on s_ack one cycle after s_req. Writes to offsets 0x4, 0x8 and 0xC store all 32 bits, and reads return them. Offset 0x4 drives aout1 and offset 0x8 drives aout2.
- R3: Reading offset 0x0 returns the live debug switch inputs in bits 7:0 and the run bit in bit 8, with bits 31:9 always 0. Writes to offset 0x0 change only bit 8.
- R4: A slave access outside the window, or one with a nonzero byte offset, is not acknowledged and changes no register.
- R5: While the run bit is 0 and the sequencer is idle, m_req stays 0.
- R6: Every sweep begins with a write transfer (m_we=1) to BCR_ADDR carrying TRIG_WORD (default 0x0000_1000). The first request after leaving idle is this write.
- R7: After the trigger, exactly N read transfers (m_we=0) go to BUF_ADDR. N is chan_cnt clamped to 1..MAX_CH, so 0 gives 1 and any value above 8 gives 8 with the defaults.
- R8: Each read's data appears on samp_data one cycle after its acknowledge, with samp_valid high for that single cycle and samp_chan counting 0..N-1 within the sweep. With SWAP_BYTES=1 (the default), the bytes are reversed, so that read bits 7:0 appear in bits 31:24.
- R9: A request, together with its address and direction, is held unchanged until m_ack is seen.
- R10: After the last read of a sweep, the sequencer issues a new trigger if the run bit is 1 and goes idle if it is 0. Clearing the run bit mid-sweep never shortens the sweep.
- R11: The channel count is captured when the trigger is acknowledged, so changing chan_cnt during a sweep does not alter that sweep's read count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req | input | 1 | Slave access strobe |
| s_we | input | 1 | Slave write (1) or read (0) |
| s_addr | input | 32 | Slave byte address |
| s_wdata | input | 32 | Slave write data |
| s_ack | output | 1 | Slave acknowledge, one cycle after an in-window access |
| s_rdata | output | 32 | Slave read data, valid with s_ack |
| dbg_sw | input | 8 | Debug switch inputs |
| aout1 | output | 32 | Analog output channel 1 value |
| aout2 | output | 32 | Analog output channel 2 value |
| chan_cnt | input | 4 | Number of active card channels |
| m_req | output | 1 | Master transfer request |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | 32 | Master transfer address |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data, valid with m_ack |
| m_ack | input | 1 | Master transfer acknowledge |
| samp_valid | output | 1 | Sample strobe |
| samp_chan | output | 3 | Channel index of the sample |
| samp_data | output | 32 | Sample word |

## Verification
On every cycle, the assertions check the following:
- a pending master request keeps its address and direction;
- each request that rises out of idle is the trigger write;
- every sample strobe follows an acknowledged read, and its channel index stays within the captured count;
- the sequencer reaches idle only after the last channel with the run bit clear;
- slave acknowledges only follow in-window requests;
- the reserved control bits read as zero.

Only the bench scenarios can show the rest. These are the exact transfer order and count per sweep under different latencies, the clamping of channel counts 0 and 12, and the byte order of delivered samples. They also include a sweep finishing after a mid-sweep stop, a count change that is ignored until the next trigger, and registers left untouched by out-of-window accesses.

// File: rtl/acq_pkg.sv
package acq_pkg;
    parameter int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_TRIG  = 2'd2,
        ST_READ  = 2'd3
    } acq_state_e;
endpackage

// File: rtl/acq_lane.sv
module acq_lane #(
    parameter int unsigned W    = 32,
    parameter bit          SWAP = 1'b1
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned NB = W / 8;

    generate
        if (SWAP) begin : g_swap
            for (genvar b = 0; b < NB; b++) begin : g_byte
                assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/acq_regs.sv
module acq_regs
    import acq_pkg::*;
#(
    parameter int unsigned      S_AW      = 32,
    parameter logic [S_AW-1:0]  BASE_ADDR = 32'h0004_0000,
    parameter int unsigned      SW_W      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s_req,
    input  logic            s_we,
    input  logic [S_AW-1:0] s_addr,
    input  word_t           s_wdata,
    output logic            s_ack,
    output word_t           s_rdata,
    input  logic [SW_W-1:0] dbg_sw,
    output logic            run,
    output word_t           aout1,
    output word_t           aout2
);
    localparam int unsigned RUN_BIT = SW_W;

    typedef struct packed {
        logic  run;
        word_t ao1;
        word_t ao2;
        word_t scr;
        word_t rdata;
        logic  ack;
    } regs_t;

    regs_t r_q, r_d;
    logic  hit;
    word_t ctrl_word;

    always_comb begin
        hit = (s_addr[S_AW-1:4] == BASE_ADDR[S_AW-1:4]) && (s_addr[1:0] == 2'b00);
        ctrl_word = '0;
        ctrl_word[SW_W-1:0] = dbg_sw;
        ctrl_word[RUN_BIT]  = r_q.run;

        r_d     = r_q;
        r_d.ack = s_req && hit;
        if (s_req && hit) begin
            if (s_we) begin
                unique case (s_addr[3:2])
                    2'd0: r_d.run = s_wdata[RUN_BIT];
                    2'd1: r_d.ao1 = s_wdata;
                    2'd2: r_d.ao2 = s_wdata;
                    default: r_d.scr = s_wdata;
                endcase
            end else begin
                unique case (s_addr[3:2])
                    2'd0: r_d.rdata = ctrl_word;
                    2'd1: r_d.rdata = r_q.ao1;
                    2'd2: r_d.rdata = r_q.ao2;
                    default: r_d.rdata = r_q.scr;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign s_ack   = r_q.ack;
    assign s_rdata = r_q.rdata;
    assign run     = r_q.run;
    assign aout1   = r_q.ao1;
    assign aout2   = r_q.ao2;

    assert_ack_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |-> $past(s_req && s_addr[S_AW-1:4] == BASE_ADDR[S_AW-1:4]));

    assert_ack_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |-> $past(s_req));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ack && $past(!s_we && s_addr[3:2] == 2'd0)) |-> (s_rdata[31:RUN_BIT+1] == '0));
endmodule

// File: rtl/acq_master.sv
module acq_master
    import acq_pkg::*;
#(
    parameter int unsigned      M_AW      = 32,
    parameter logic [M_AW-1:0]  BCR_ADDR  = 32'h8000_0000,
    parameter logic [M_AW-1:0]  BUF_ADDR  = 32'h8000_0018,
    parameter word_t            TRIG_WORD = 32'h0000_1000,
    parameter int unsigned      MAX_CH    = 8,
    localparam int unsigned     CH_W      = $clog2(MAX_CH),
    localparam int unsigned     CNT_W     = CH_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] chan_cnt,
    output logic             m_req,
    output logic             m_we,
    output logic [M_AW-1:0]  m_addr,
    output word_t            m_wdata,
    input  word_t            rd_word,
    input  logic             m_ack,
    output logic             samp_valid,
    output logic [CH_W-1:0]  samp_chan,
    output word_t            samp_data
);
    typedef struct packed {
        acq_state_e      st;
        logic [M_AW-1:0] bcr_a;
        logic [M_AW-1:0] buf_a;
        logic [CH_W-1:0] chan;
        logic [CH_W-1:0] last;
        logic            sv;
        logic [CH_W-1:0] sc;
        word_t           sd;
    } mst_t;

    mst_t             q, d;
    logic [CNT_W-1:0] lim;

    always_comb begin
        if (chan_cnt == '0)                       lim = CNT_W'(1);
        else if (chan_cnt > CNT_W'(MAX_CH))       lim = CNT_W'(MAX_CH);
        else                                      lim = chan_cnt;

        d    = q;
        d.sv = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (run) d.st = ST_SETUP;
            end
            ST_SETUP: begin
                d.bcr_a = BCR_ADDR;
                d.buf_a = BUF_ADDR;
                d.st    = ST_TRIG;
            end
            ST_TRIG: begin
                if (m_ack) begin
                    d.last = CH_W'(lim - 1'b1);
                    d.chan = '0;
                    d.st   = ST_READ;
                end
            end
            default: begin
                if (m_ack) begin
                    d.sv = 1'b1;
                    d.sc = q.chan;
                    d.sd = rd_word;
                    if (q.chan == q.last) d.st = run ? ST_TRIG : ST_IDLE;
                    else                  d.chan = q.chan + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign m_req      = (q.st == ST_TRIG) || (q.st == ST_READ);
    assign m_we       = (q.st == ST_TRIG);
    assign m_addr     = (q.st == ST_TRIG) ? q.bcr_a : q.buf_a;
    assign m_wdata    = TRIG_WORD;
    assign samp_valid = q.sv;
    assign samp_chan  = q.sc;
    assign samp_data  = q.sd;

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

    assert_trigger_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_req) |-> (m_we && m_addr == BCR_ADDR));

    assert_sample_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |-> $past(m_req && m_ack && !m_we));

    assert_chan_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |-> (samp_chan <= q.last));

    assert_stop_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && $past(q.st == ST_READ)) |-> $past(!run && q.chan == q.last));
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h0004_0000,
    parameter logic [31:0] BCR_ADDR   = 32'h8000_0000,
    parameter logic [31:0] BUF_ADDR   = 32'h8000_0018,
    parameter logic [31:0] TRIG_WORD  = 32'h0000_1000,
    parameter int unsigned MAX_CH     = 8,
    parameter bit          SWAP_BYTES = 1'b1,
    localparam int unsigned CH_W      = $clog2(MAX_CH),
    localparam int unsigned CNT_W     = CH_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_req,
    input  logic             s_we,
    input  logic [31:0]      s_addr,
    input  logic [31:0]      s_wdata,
    output logic             s_ack,
    output logic [31:0]      s_rdata,
    input  logic [7:0]       dbg_sw,
    output logic [31:0]      aout1,
    output logic [31:0]      aout2,
    input  logic [CNT_W-1:0] chan_cnt,
    output logic             m_req,
    output logic             m_we,
    output logic [31:0]      m_addr,
    output logic [31:0]      m_wdata,
    input  logic [31:0]      m_rdata,
    input  logic             m_ack,
    output logic             samp_valid,
    output logic [CH_W-1:0]  samp_chan,
    output logic [31:0]      samp_data
);
    logic  run;
    word_t rd_word;

    acq_regs #(
        .S_AW      (32),
        .BASE_ADDR (BASE_ADDR),
        .SW_W      (8)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_req   (s_req),
        .s_we    (s_we),
        .s_addr  (s_addr),
        .s_wdata (s_wdata),
        .s_ack   (s_ack),
        .s_rdata (s_rdata),
        .dbg_sw  (dbg_sw),
        .run     (run),
        .aout1   (aout1),
        .aout2   (aout2)
    );

    acq_lane #(
        .W    (WORD_W),
        .SWAP (SWAP_BYTES)
    ) u_lane (
        .din  (m_rdata),
        .dout (rd_word)
    );

    acq_master #(
        .M_AW      (32),
        .BCR_ADDR  (BCR_ADDR),
        .BUF_ADDR  (BUF_ADDR),
        .TRIG_WORD (TRIG_WORD),
        .MAX_CH    (MAX_CH)
    ) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .chan_cnt   (chan_cnt),
        .m_req      (m_req),
        .m_we       (m_we),
        .m_addr     (m_addr),
        .m_wdata    (m_wdata),
        .rd_word    (rd_word),
        .m_ack      (m_ack),
        .samp_valid (samp_valid),
        .samp_chan  (samp_chan),
        .samp_data  (samp_data)
    );
endmodule

// File: tb/acq_sequencer_tb.sv
module acq_sequencer_tb;
    localparam int CLK_P = 10;
    localparam logic [31:0] BASE = 32'h0004_0000;
    localparam logic [31:0] BCR  = 32'h8000_0000;
    localparam logic [31:0] BUFA = 32'h8000_0018;
    localparam logic [31:0] TRIG = 32'h0000_1000;
    localparam logic [31:0] RUNW = 32'h0000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_req = 1'b0, s_we = 1'b0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic s_ack;
    logic [31:0] s_rdata;
    logic [7:0] dbg_sw = 8'hA5;
    logic [31:0] aout1, aout2;
    logic [3:0] chan_cnt = 4'd1;
    logic m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic [31:0] m_rdata;
    logic m_ack;
    logic samp_valid;
    logic [2:0] samp_chan;
    logic [31:0] samp_data;

    int checks = 0, fails = 0;
    int lat = 0, wcnt = 0, rd_idx = 0;
    int n_log = 0, n_smp = 0;
    logic        lg_we[64];
    logic [31:0] lg_addr[64];
    logic [31:0] lg_data[64];
    logic [2:0]  sm_ch[64];
    logic [31:0] sm_d[64];

    always #(CLK_P/2) clk = ~clk;

    acq_sequencer #(
        .BASE_ADDR (BASE), .BCR_ADDR (BCR), .BUF_ADDR (BUFA),
        .TRIG_WORD (TRIG), .MAX_CH (8), .SWAP_BYTES (1'b1)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .s_req (s_req), .s_we (s_we), .s_addr (s_addr), .s_wdata (s_wdata),
        .s_ack (s_ack), .s_rdata (s_rdata), .dbg_sw (dbg_sw),
        .aout1 (aout1), .aout2 (aout2), .chan_cnt (chan_cnt),
        .m_req (m_req), .m_we (m_we), .m_addr (m_addr), .m_wdata (m_wdata),
        .m_rdata (m_rdata), .m_ack (m_ack),
        .samp_valid (samp_valid), .samp_chan (samp_chan), .samp_data (samp_data)
    );

    function automatic logic [31:0] swap32(logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // card responder: acknowledges after lat waiting cycles and logs each transfer
    initial begin
        m_ack = 1'b0;
        m_rdata = '0;
        forever begin
            @(posedge clk); #1;
            if (m_ack) m_ack = 1'b0;
            else if (m_req && rst_n) begin
                if (wcnt >= lat) begin
                    m_ack = 1'b1;
                    wcnt = 0;
                    if (!m_we) begin
                        m_rdata = 32'h0102_0300 + rd_idx;
                        rd_idx++;
                    end
                    if (n_log < 64) begin
                        lg_we[n_log]   = m_we;
                        lg_addr[n_log] = m_addr;
                        lg_data[n_log] = m_we ? m_wdata : m_rdata;
                        n_log++;
                    end
                end else wcnt++;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (samp_valid && n_smp < 64) begin
                sm_ch[n_smp] = samp_chan;
                sm_d[n_smp]  = samp_data;
                n_smp++;
            end
        end
    end

    task automatic sw_write(logic [31:0] a, logic [31:0] v, output logic ack);
        @(posedge clk); #1;
        s_req = 1'b1; s_we = 1'b1; s_addr = a; s_wdata = v;
        @(posedge clk); #1;
        s_req = 1'b0; s_we = 1'b0;
        ack = s_ack;
    endtask

    task automatic sw_read(logic [31:0] a, output logic [31:0] v, output logic ack);
        @(posedge clk); #1;
        s_req = 1'b1; s_we = 1'b0; s_addr = a;
        @(posedge clk); #1;
        s_req = 1'b0;
        ack = s_ack;
        v = s_rdata;
    endtask

    task automatic wait_log(int target, string req);
        int t = 0;
        while (n_log < target && t < 3000) begin
            @(posedge clk);
            t++;
        end
        chk(req, "transfers reached", 32'(n_log >= target), 32'd1);
    endtask

    task automatic clear_logs();
        n_log = 0;
        n_smp = 0;
    endtask

    // checks the logged transfers against the expected sweep pattern
    task automatic check_sweeps(int n, string req);
        int rj = 0;
        chk(req, "log ends on sweep boundary", 32'(n_log % (n + 1)), 32'd0);
        for (int i = 0; i < n_log; i++) begin
            if (i % (n + 1) == 0) begin
                chk("R6", "trigger is write", 32'(lg_we[i]), 32'd1);
                chk("R6", "trigger address", lg_addr[i], BCR);
                chk("R6", "trigger data", lg_data[i], TRIG);
            end else begin
                chk("R7", "read direction", 32'(lg_we[i]), 32'd0);
                chk("R7", "read address", lg_addr[i], BUFA);
                if (rj < n_smp) begin
                    chk("R8", "sample channel", 32'(sm_ch[rj]), 32'(rj % n));
                    chk("R8", "sample swapped data", sm_d[rj], swap32(lg_data[i]));
                end
                rj++;
            end
        end
        chk("R8", "sample count", 32'(n_smp), 32'(rj));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic a;
        @(negedge clk);
        chk("R1", "m_req", 32'(m_req), 32'd0);
        chk("R1", "samp_valid", 32'(samp_valid), 32'd0);
        chk("R1", "s_ack", 32'(s_ack), 32'd0);
        chk("R1", "aout1", aout1, 32'd0);
        chk("R1", "aout2", aout2, 32'd0);
        sw_read(BASE + 32'hC, v, a);
        chk("R1", "scratch", v, 32'd0);
        sw_read(BASE, v, a);
        chk("R1", "control with run clear", v, 32'h0000_00A5);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        logic a;
        sw_write(BASE + 32'h4, 32'h1234_5678, a);
        chk("R2", "write ack", 32'(a), 32'd1);
        sw_write(BASE + 32'h8, 32'h9ABC_DEF0, a);
        sw_write(BASE + 32'hC, 32'hCAFE_0001, a);
        sw_read(BASE + 32'h4, v, a);
        chk("R2", "read ack", 32'(a), 32'd1);
        chk("R2", "offset 4", v, 32'h1234_5678);
        sw_read(BASE + 32'h8, v, a);
        chk("R2", "offset 8", v, 32'h9ABC_DEF0);
        sw_read(BASE + 32'hC, v, a);
        chk("R2", "offset C", v, 32'hCAFE_0001);
        chk("R2", "aout1 port", aout1, 32'h1234_5678);
        chk("R2", "aout2 port", aout2, 32'h9ABC_DEF0);
        sw_write(BASE, 32'hFFFF_FE00, a);
        sw_read(BASE, v, a);
        chk("R3", "reserved bits zero, run clear", v, 32'h0000_00A5);
        dbg_sw = 8'h3C;
        sw_read(BASE, v, a);
        chk("R3", "live switches", v, 32'h0000_003C);
    endtask

    task automatic t_window();
        logic [31:0] v;
        logic a;
        sw_write(BASE + 32'h10, 32'h0000_DEAD, a);
        chk("R4", "no ack above window", 32'(a), 32'd0);
        sw_write(BASE + 32'h5, 32'h0000_BEEF, a);
        chk("R4", "no ack unaligned", 32'(a), 32'd0);
        sw_read(BASE - 32'h4, v, a);
        chk("R4", "no ack below window", 32'(a), 32'd0);
        sw_read(BASE + 32'h4, v, a);
        chk("R4", "offset 4 untouched", v, 32'h1234_5678);
        sw_read(BASE, v, a);
        chk("R4", "run still clear", v & RUNW, 32'd0);
    endtask

    task automatic t_idle_quiet();
        int seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (m_req) seen++;
        end
        chk("R5", "no request while stopped", 32'(seen), 32'd0);
    endtask

    task automatic t_sweeps(logic [3:0] cnt, int l, int n_exp, string req);
        logic a;
        clear_logs();
        chan_cnt = cnt;
        lat = l;
        sw_write(BASE, RUNW, a);
        wait_log(2 * (n_exp + 1), req);
        sw_write(BASE, 32'd0, a);
        repeat (100) @(posedge clk);
        @(negedge clk);
        chk("R10", "idle after stop", 32'(m_req), 32'd0);
        chk("R10", "re-triggered at least once", 32'(n_log >= 2 * (n_exp + 1)), 32'd1);
        check_sweeps(n_exp, req);
    endtask

    task automatic t_stop_mid();
        logic a;
        clear_logs();
        chan_cnt = 4'd8;
        lat = 3;
        sw_write(BASE, RUNW, a);
        wait_log(2, "R10");
        sw_write(BASE, 32'd0, a);
        repeat (100) @(posedge clk);
        @(negedge clk);
        chk("R10", "one full sweep only", 32'(n_log), 32'd9);
        chk("R10", "idle", 32'(m_req), 32'd0);
        check_sweeps(8, "R10");
    endtask

    task automatic t_count_capture();
        logic a;
        clear_logs();
        chan_cnt = 4'd5;
        lat = 2;
        sw_write(BASE, RUNW, a);
        wait_log(2, "R11");
        chan_cnt = 4'd2;
        sw_write(BASE, 32'd0, a);
        repeat (100) @(posedge clk);
        @(negedge clk);
        chk("R11", "sweep kept count 5", 32'(n_log), 32'd6);
        check_sweeps(5, "R11");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_window();
        t_idle_quiet();
        t_sweeps(4'd3, 0, 3, "R7");
        t_sweeps(4'd0, 1, 1, "R7");
        t_sweeps(4'd12, 2, 8, "R7");
        t_sweeps(4'd2, 4, 2, "R9");
        t_stop_mid();
        t_count_capture();
        finish_run();
    end
endmodule